// File: doc/BRIEF.md
# Programmable Divided Countdown Timer

This block is a per-core local timer. Software programs a divide setting, an initial count and a timer control word that holds a mask bit, a periodic/one-shot select, a delivery-status bit and an 8-bit vector. Writing the initial count loads the live counter, which then steps down by one after each run of input clock cycles whose length is the programmed divisor. When the counter passes from one to zero the timer has expired. A periodic timer then reloads from the initial count. A one-shot timer stays at zero.

Each expiry adds one to a small saturating pending count. The block raises an interrupt request carrying the programmed vector while that count is non-zero, the control word is unmasked and the unit is software-enabled. An acknowledge that arrives while the request is high removes one pending expiry. Clearing the software-enable bit masks the timer and discards every pending expiry. Registers are reached through a simple write strobe and a combinational read port. Register words: 0 enable (bit 0), 1 timer control word, 2 divide setting (bits 3:0), 3 initial count, 4 current count (read-only).

Top module: `prog_countdown_timer`

## Requirements
- R1: After a synchronous reset the control word reads 0x0001_0000 (masked), the divide setting, initial count, current count and enable read zero, and irq_req is low.
- R2: The divisor is 2 to the power of ((({d[3], d[1:0]}) + 1) mod 8), where d is the divide setting. So setting 0xB divides by 1, 0x0 divides by 2 and 0xA divides by 128.
- R3: A running current count drops by exactly one after every divisor-length run of clock cycles, and word 4 returns its live value.
- R4: Writing word 3 loads the current count with the written value in the same edge, restarts the divisor phase and clears all pending expiries.
- R5: An initial count of zero leaves the timer stopped: the current count reads zero and no expiry occurs.
- R6: At expiry, control bit 17 set reloads the current count from the initial count. With bit 17 clear the count stays at zero.
- R7: Each expiry adds one pending expiry. irq_req is high exactly when pending is non-zero, control bit 16 (mask) is clear and the enable bit is set, and irq_vector equals control bits 7:0.
- R8: irq_ack removes one pending expiry only in a cycle where irq_req is high. Otherwise it has no effect.
- R9: Writing word 0 with bit 0 clear sets the mask bit 16 in the control word and clears all pending expiries.
- R10: A write to the control word keeps only bits 17, 16, 12 and 7:0. While the unit is disabled, bit 16 is forced to one.
- R11: The pending count saturates at 2^PEND_W-1 (15 by default), so at most that many acknowledges are granted after a burst of expiries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word written |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register word read |
| rd_data | output | 32 | Read data, combinational |
| irq_ack | input | 1 | Interrupt acceptance |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 8 | Vector of the request |

## Verification
The bench aims at the divisor encoding at its extremes (divide by 1, 2 and 128). A design that packed the divide bits in the wrong order, or that did not wrap the sum, would count at the wrong rate. It restarts a running count and checks that a design which did not reset the divisor phase, or did not clear pending expiries, drifts by cycles or keeps requesting. It builds a burst of expiries past the pending limit and counts the granted acknowledges, which exposes both a wrapping counter and one that drops acknowledges. It also writes the control word while disabled and disables while a request is active, so a design that keeps stray bits, fails to force the mask, or leaves stale expiries shows a wrong read value or a lingering request.

// File: rtl/tmr_pkg.sv
// Shared constants and helpers for the divided countdown timer.
// Assumes a 32-bit register bus and word-granular register addresses.
package tmr_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int SHIFT_W = 3;
    localparam int PRE_W   = (1 << SHIFT_W) - 1;
    localparam int VEC_W   = 8;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_LVT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_DIV  = 3'd2;
    localparam logic [ADDR_W-1:0] A_INIT = 3'd3;
    localparam logic [ADDR_W-1:0] A_CUR  = 3'd4;

    localparam int MASK_BIT = 16;
    localparam int PER_BIT  = 17;

    localparam logic [DATA_W-1:0] LVT_KEEP   = 32'h0003_10FF;
    localparam logic [DATA_W-1:0] LVT_MASKED = 32'h0001_0000;

    // Turns the divide setting into a power-of-two exponent (wraps mod 8).
    function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] cfg);
        return {cfg[3], cfg[1:0]} + SHIFT_W'(1);
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
// Divisor phase counter: pulses tick once every 2**shift cycles while run
// is high. Assumes restart and run are registered-state driven signals.
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] last;

    // Last phase value of a divisor period.
    always_comb last = PRE_W'((32'd1 << shift) - 32'd1);

    assign tick = run && !restart && (phase_q >= last);

    // Advance the phase, returning to zero on tick, restart or idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (restart || !run || tick)
            phase_q <= '0;
        else
            phase_q <= phase_q + PRE_W'(1);
    end
endmodule

// File: rtl/tmr_counter.sv
// Current-count register: loads on software write, steps down on tick,
// flags expiry when stepping from one, reloads when periodic.
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             periodic,
    input  logic             tick,
    output logic [CNT_W-1:0] cur,
    output logic             expire,
    output logic             run
);
    logic [CNT_W-1:0] cur_q;

    assign cur    = cur_q;
    assign run    = (cur_q != '0);
    assign expire = tick && (cur_q == CNT_W'(1));

    // Load, decrement or reload the live count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= '0;
        else if (load)
            cur_q <= load_val;
        else if (tick) begin
            if (cur_q == CNT_W'(1))
                cur_q <= periodic ? reload_val : '0;
            else
                cur_q <= cur_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/tmr_pending.sv
// Saturating pending-expiry count and request gating.
// Assumes allow combines unit enable and unmasked control word.
module tmr_pending #(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic              ack,
    input  logic              allow,
    output logic              req,
    output logic [PEND_W-1:0] level
);
    localparam logic [PEND_W-1:0] FULL = '1;
    logic [PEND_W-1:0] lvl_q;
    logic              dec;

    assign level = lvl_q;
    assign req   = allow && (lvl_q != '0);
    assign dec   = ack && req;

    // Count expiries up and accepted deliveries down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl_q <= '0;
        else if (clr)
            lvl_q <= '0;
        else if (inc && !dec && lvl_q != FULL)
            lvl_q <= lvl_q + PEND_W'(1);
        else if (dec && !inc)
            lvl_q <= lvl_q - PEND_W'(1);
    end
endmodule

// File: rtl/prog_countdown_timer.sv
// Programmable divided countdown timer with register file, prescaler,
// counter and pending logic. Assumes one register write per cycle.
module prog_countdown_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vector
);
    logic              en_q;
    logic [DATA_W-1:0] lvt_q;
    logic [3:0]        div_q;
    logic [CNT_W-1:0]  init_q;
    logic [CNT_W-1:0]  cur;
    logic              tick, expire, run;
    logic [PEND_W-1:0] pend;
    logic              wr_ctrl, wr_lvt, wr_div, wr_init, disable_wr;

    assign wr_ctrl    = wr_en && (wr_addr == A_CTRL);
    assign wr_lvt     = wr_en && (wr_addr == A_LVT);
    assign wr_div     = wr_en && (wr_addr == A_DIV);
    assign wr_init    = wr_en && (wr_addr == A_INIT);
    assign disable_wr = wr_ctrl && !wr_data[0];

    // Software-visible configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            lvt_q  <= LVT_MASKED;
            div_q  <= '0;
            init_q <= '0;
        end else begin
            if (wr_ctrl)
                en_q <= wr_data[0];
            if (disable_wr)
                lvt_q[MASK_BIT] <= 1'b1;
            else if (wr_lvt)
                lvt_q <= (wr_data & LVT_KEEP) | (en_q ? '0 : LVT_MASKED);
            if (wr_div)
                div_q <= wr_data[3:0];
            if (wr_init)
                init_q <= wr_data[CNT_W-1:0];
        end
    end

    tmr_prescaler u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .restart(wr_init),
        .shift  (div_shift(div_q)),
        .tick   (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_init),
        .load_val  (wr_data[CNT_W-1:0]),
        .reload_val(init_q),
        .periodic  (lvt_q[PER_BIT]),
        .tick      (tick),
        .cur       (cur),
        .expire    (expire),
        .run       (run)
    );

    tmr_pending #(.PEND_W(PEND_W)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (wr_init || disable_wr),
        .inc  (expire),
        .ack  (irq_ack),
        .allow(en_q && !lvt_q[MASK_BIT]),
        .req  (irq_req),
        .level(pend)
    );

    assign irq_vector = lvt_q[VEC_W-1:0];

    // Read multiplexer.
    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = {{(DATA_W-1){1'b0}}, en_q};
            A_LVT:   rd_data = lvt_q;
            A_DIV:   rd_data = {{(DATA_W-4){1'b0}}, div_q};
            A_INIT:  rd_data = DATA_W'(init_q);
            A_CUR:   rd_data = DATA_W'(cur);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
// Protocol checks for the countdown timer, bound into the top module.
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              en_q,
    input logic [DATA_W-1:0] lvt_q,
    input logic [CNT_W-1:0]  cur,
    input logic [PEND_W-1:0] pend,
    input logic              irq_req
);
    logic ld;
    assign ld = wr_en && (wr_addr == A_INIT);

    a_r7_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (en_q && !lvt_q[MASK_BIT]));

    a_r4_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cur == $past(wr_data[CNT_W-1:0]) && pend == '0));

    a_r9_disable_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL && !wr_data[0]) |=> (lvt_q[MASK_BIT] && pend == '0 && !irq_req));

    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == '0 && !ld) |=> (cur == '0));

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cur > CNT_W'(1) && !ld) |=> (cur == $past(cur) || cur == $past(cur) - CNT_W'(1)));

    a_r10_forced_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_LVT && !en_q) |=> (lvt_q[MASK_BIT] && (lvt_q & ~LVT_KEEP) == '0));
endmodule

bind prog_countdown_timer tmr_checker #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .en_q   (en_q),
    .lvt_q  (lvt_q),
    .cur    (cur),
    .pend   (pend),
    .irq_req(irq_req)
);

// File: tb/sim_prog_countdown_timer.sv
module sim_prog_countdown_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic        irq_ack = 1'b0;
    logic [31:0] rd_data;
    logic        irq_req;
    logic [7:0]  irq_vector;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    prog_countdown_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_vector(irq_vector)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference state
    bit          m_en;
    logic [31:0] m_lvt, m_init, m_cur;
    logic [3:0]  m_div;
    int          m_phase, m_pend;

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {31'd0, m_en};
            3'd1: return m_lvt;
            3'd2: return {28'd0, m_div};
            3'd3: return m_init;
            3'd4: return m_cur;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R9";
            3'd1: return "R10";
            3'd2: return "R2";
            3'd3: return "R4";
            default: return "R3";
        endcase
    endfunction

    // Reference update on each edge, then compare away from the edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_lvt = 32'h0001_0000; m_div = 0; m_init = 0;
            m_cur = 0; m_phase = 0; m_pend = 0;
        end else begin
            bit req_old;
            int sh, dv, ex;
            req_old = (m_pend > 0) && !m_lvt[16] && m_en;
            sh = (((m_div[3] ? 4 : 0) + int'(m_div[1:0])) + 1) % 8;
            dv = 1 << sh;
            ex = 0;
            if (wr_en && wr_addr == 3'd3) begin
                m_cur = wr_data; m_phase = 0;
            end else if (m_cur != 0) begin
                if (m_phase + 1 >= dv) begin
                    m_phase = 0;
                    if (m_cur == 1) begin
                        ex = 1;
                        m_cur = m_lvt[17] ? m_init : 32'd0;
                    end else
                        m_cur = m_cur - 1;
                end else
                    m_phase++;
            end else
                m_phase = 0;
            if ((wr_en && wr_addr == 3'd3) || (wr_en && wr_addr == 3'd0 && !wr_data[0]))
                m_pend = 0;
            else begin
                m_pend = m_pend + ex - ((irq_ack && req_old) ? 1 : 0);
                if (m_pend > 15) m_pend = 15;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin
                        if (!wr_data[0]) m_lvt[16] = 1'b1;
                        m_en = wr_data[0];
                    end
                    3'd1: m_lvt = (wr_data & 32'h0003_10FF) | (m_en ? 32'd0 : 32'h0001_0000);
                    3'd2: m_div = wr_data[3:0];
                    3'd3: m_init = wr_data;
                    default: ;
                endcase
            end
        end
        #5;
        if (!done) begin
            bit er;
            er = (m_pend > 0) && !m_lvt[16] && m_en;
            chk("R7", "irq_req", irq_req, er);
            if (er) chk("R7", "irq_vector", irq_vector, m_lvt[7:0]);
            chk(tag_of(rd_addr), "rd_data", rd_data, m_read(rd_addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_expect(input logic [2:0] a, input logic [31:0] e, input string tag);
        rd_addr = a;
        #1;
        chk(tag, "read", rd_data, e);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_expect(3'd1, 32'h0001_0000, "R1");
        rd_expect(3'd2, 32'd0, "R1");
        rd_expect(3'd3, 32'd0, "R1");
        rd_expect(3'd4, 32'd0, "R1");
        rd_expect(3'd0, 32'd0, "R1");
        chk("R1", "irq_req", irq_req, 0);
        // R10 write while disabled
        wr(3'd1, 32'hFFFF_FFFF);
        rd_expect(3'd1, 32'h0003_10FF, "R10");
        wr(3'd0, 32'd1);
        wr(3'd1, 32'h0000_002A);
        rd_expect(3'd1, 32'h0000_002A, "R10");
        // R2 divide by 1, R3 stepping, R6 one-shot
        wr(3'd2, 32'h0000_000B);
        rd_addr = 3'd4;
        wr(3'd3, 32'd5);
        wait_n(3);
        rd_expect(3'd4, 32'd2, "R3");
        wait_n(3);
        rd_expect(3'd4, 32'd0, "R6");
        chk("R7", "irq_req", irq_req, 1);
        chk("R7", "irq_vector", irq_vector, 8'h2A);
        // R8 acknowledge
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
        chk("R8", "irq_req after ack", irq_req, 0);
        irq_ack = 1; wait_n(3); irq_ack = 0;
        chk("R8", "irq_req idle ack", irq_req, 0);
        // R11 saturation
        wr(3'd1, 32'h0002_0033);
        wr(3'd3, 32'd1);
        wait_n(30);
        wr(3'd1, 32'h0000_0033);
        wait_n(2);
        k = 0;
        irq_ack = 1;
        while (irq_req && k < 40) begin
            @(negedge clk);
            k++;
        end
        irq_ack = 0;
        chk("R11", "granted acks", k, 15);
        // R9 disable clears pending and masks
        wr(3'd3, 32'd2);
        wait_n(5);
        chk("R7", "irq_req before disable", irq_req, 1);
        wr(3'd0, 32'd0);
        chk("R9", "irq_req after disable", irq_req, 0);
        rd_expect(3'd1, 32'h0001_0033, "R9");
        wr(3'd1, 32'h0002_3456);
        rd_expect(3'd1, 32'h0003_1056, "R10");
        // R5 zero count
        wr(3'd0, 32'd1);
        wr(3'd1, 32'h0000_0044);
        wr(3'd3, 32'd0);
        wait_n(20);
        rd_expect(3'd4, 32'd0, "R5");
        chk("R5", "irq_req", irq_req, 0);
        // R4 restart mid-count
        wr(3'd3, 32'd100);
        wait_n(10);
        wr(3'd3, 32'd7);
        rd_expect(3'd4, 32'd7, "R4");
        // R2 divide by 2
        wr(3'd2, 32'h0000_0000);
        wr(3'd3, 32'd9);
        wait_n(4);
        rd_expect(3'd4, 32'd7, "R2");
        // R2 divide by 128
        wr(3'd2, 32'h0000_000A);
        wr(3'd3, 32'd3);
        wait_n(127);
        rd_expect(3'd4, 32'd3, "R2");
        wait_n(1);
        rd_expect(3'd4, 32'd2, "R2");
        // R6 periodic with mid-run divide change, compared each cycle
        wr(3'd1, 32'h0002_0055);
        wr(3'd2, 32'h0000_0003);
        wr(3'd3, 32'd3);
        wait_n(100);
        wr(3'd2, 32'h0000_0008);
        wait_n(200);
        chk("R6", "periodic still running", (rd_data != 0) || irq_req, 1);
        @(negedge clk); irq_ack = 1;
        wait_n(4); irq_ack = 0;
        wait_n(10);
        finish_run();
    end
endmodule